// File: doc/BRIEF.md
# AHB-Lite Memory Slave

This block is a single-master AHB-Lite slave that holds a small word-addressed memory. It registers the address and control phase on the clock edge where the bus is ready, then finishes the matching data phase one or more cycles later. It handles single transfers and incrementing bursts of four or eight beats, and it can add a fixed number of wait states set by a parameter.

The slave answers every transfer with one of two responses: OKAY, or a two-cycle ERROR. A transfer gets ERROR when its address falls outside the memory, when it is not a full-word transfer, or when it is not word-aligned. The memory is cleared by reset. A write stores its data word in the final cycle of its data phase. A read drives the stored word during the final cycle of its data phase.

Top module: `memslv_ahb`

## Requirements
- R1: A transfer starts a data phase only when `sel_i`, `rdy_i` and `trans_i[1]` are all high in the same clock cycle, where `trans_i` is 2'b10 for NONSEQ or 2'b11 for SEQ. If `rdy_i` is low, the address phase presented is ignored.
- R2: A transfer that is IDLE (2'b00), BUSY (2'b01) or unselected completes with zero wait states and an OKAY response (`resp_o` = 2'b00). It leaves the memory unchanged.
- R3: A write stores the `wdata_i` value held in its final data-phase cycle at word index `addr_i / (DATA_W/8)`. A later read of that address returns the word, including a read issued directly after the write.
- R4: After reset, `rdy_o` is 1 and `resp_o` is OKAY, and every word reads as zero until it is written.
- R5: Every accepted transfer with no error holds `rdy_o` low for exactly WAIT_STATES cycles (0 to 3). `rdy_o` then goes high with an OKAY response.
- R6: Incrementing bursts of four beats (`burst_i` 3'b011) and eight beats (`burst_i` 3'b101) are handled. A burst is a NONSEQ beat followed by SEQ beats at rising word addresses. A BUSY beat may appear between them. Each beat reads or writes its own word and gets the R5 timing.
- R7: A transfer gets an ERROR response with no memory action when any of these holds: its address is at or above DEPTH*DATA_W/8, `size_i` is not log2(DATA_W/8) (3'd2 for 32 bits), or its low address bits are not zero. The ERROR lasts two cycles. In the first cycle `rdy_o` is 0 and `resp_o` is 2'b01. In the second cycle `rdy_o` is 1 and `resp_o` is 2'b01.
- R8: `resp_o` only ever takes the values 2'b00 and 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select from the address decoder |
| addr_i | input | ADDR_W | Byte address of the address phase |
| trans_i | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 3 | log2 of the transfer size in bytes |
| burst_i | input | 3 | Burst kind, for information only |
| lock_i | input | 1 | Locked-sequence flag, for information only |
| wdata_i | input | DATA_W | Write data during the data phase |
| rdy_i | input | 1 | Bus-wide ready; 1 when the previous data phase has finished |
| rdy_o | output | 1 | Ready from this slave; 0 inserts a wait state |
| resp_o | output | 2 | Transfer response: 00 OKAY, 01 ERROR |
| rdata_o | output | DATA_W | Read data, valid in the final cycle of a read |

## Verification
An address phase is registered at the edge where the bench sees the bus ready. Its data phase then takes up the next WAIT_STATES+1 cycles for an access with no error. An error takes exactly two cycles. IDLE, BUSY and unselected beats take one cycle. The bench pushes the expected response, wait count and read data into a queue at each accepting edge. A monitor samples at every falling edge: it counts low-ready cycles for the item at the head of the queue and compares that item when ready goes high. A result is therefore checked exactly in the cycle it is due, and an extra or missing wait state shows up as a mismatch.

// File: rtl/memslv_pkg.sv
package memslv_pkg;
   typedef enum logic [1:0] {
      TR_IDLE = 2'b00,
      TR_BUSY = 2'b01,
      TR_NSEQ = 2'b10,
      TR_SEQ  = 2'b11
   } trans_e;

   localparam logic [1:0] RSP_OKAY  = 2'b00;
   localparam logic [1:0] RSP_ERROR = 2'b01;
endpackage

// File: rtl/memslv_capture.sv
module memslv_capture #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int OFS    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              rdy_i,
   input  logic [1:0]        trans_i,
   input  logic              write_i,
   input  logic [2:0]        size_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              start_ok,
   output logic              dp_valid,
   output logic              dp_write,
   output logic              dp_err,
   output logic [IDX_W-1:0]  dp_idx
);
   logic take, hi_zero, aligned, size_ok, bad;

   if (ADDR_W > OFS + IDX_W) begin : g_hi
      assign hi_zero = (addr_i[ADDR_W-1:OFS+IDX_W] == '0);
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   assign aligned  = (addr_i[OFS-1:0] == '0);
   assign size_ok  = (size_i == 3'(OFS));
   assign bad      = !(hi_zero && aligned && size_ok);
   assign take     = sel_i && rdy_i && trans_i[1];
   assign start_ok = take && !bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_valid <= 1'b0;
         dp_write <= 1'b0;
         dp_err   <= 1'b0;
         dp_idx   <= '0;
      end else if (rdy_i) begin
         dp_valid <= take;
         dp_write <= write_i;
         dp_err   <= take && bad;
         dp_idx   <= addr_i[OFS +: IDX_W];
      end
   end
endmodule

// File: rtl/memslv_wait.sv
module memslv_wait #(
   parameter int WAIT_STATES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   if (WAIT_STATES == 0) begin : g_nowait
      logic unused_sink;
      assign unused_sink = ^{clk, rst_n, load};
      assign done = 1'b1;
   end else begin : g_count
      localparam logic [1:0] LOADV = 2'(WAIT_STATES);
      logic [1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (load)       cnt <= LOADV;
         else if (cnt != '0)  cnt <= cnt - 2'd1;
      end
      assign done = (cnt == '0);
   end
endmodule

// File: rtl/memslv_store.sv
module memslv_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/memslv_ahb.sv
module memslv_ahb #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 32,
   parameter int DEPTH       = 64,
   parameter int WAIT_STATES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        trans_i,
   input  logic              write_i,
   input  logic [2:0]        size_i,
   input  logic [2:0]        burst_i,
   input  logic              lock_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rdy_i,
   output logic              rdy_o,
   output logic [1:0]        resp_o,
   output logic [DATA_W-1:0] rdata_o
);
   import memslv_pkg::*;

   localparam int BYTES = DATA_W / 8;
   localparam int OFS   = $clog2(BYTES);
   localparam int IDX_W = $clog2(DEPTH);

   if (WAIT_STATES < 0 || WAIT_STATES > 3) begin : g_chk_wait
      $error("WAIT_STATES must lie in 0..3");
   end
   if (DATA_W < 32 || DATA_W > 1024 || (1 << OFS) * 8 != DATA_W) begin : g_chk_data
      $error("DATA_W must be a power of two from 32 to 1024");
   end
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < OFS + IDX_W) begin : g_chk_addr
      $error("ADDR_W too narrow for DEPTH words");
   end

   logic              start_ok, dp_valid, dp_write, dp_err, wdone, err_second;
   logic [IDX_W-1:0]  dp_idx;
   logic [DATA_W-1:0] mem_rd;
   logic              mem_we, unused_ctrl;

   assign unused_ctrl = ^{burst_i, lock_i};

   memslv_capture #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS(OFS)) u_cap (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rdy_i(rdy_i),
      .trans_i(trans_i), .write_i(write_i), .size_i(size_i), .addr_i(addr_i),
      .start_ok(start_ok), .dp_valid(dp_valid), .dp_write(dp_write),
      .dp_err(dp_err), .dp_idx(dp_idx)
   );

   memslv_wait #(.WAIT_STATES(WAIT_STATES)) u_wait (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .done(wdone)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  err_second <= 1'b0;
      else if (rdy_i)              err_second <= 1'b0;
      else if (dp_valid && dp_err) err_second <= 1'b1;
   end

   assign mem_we = dp_valid && !dp_err && dp_write && wdone;

   memslv_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .idx(dp_idx),
      .wdata(wdata_i), .rdata(mem_rd)
   );

   always_comb begin
      rdy_o   = 1'b1;
      resp_o  = RSP_OKAY;
      rdata_o = '0;
      if (dp_valid) begin
         if (dp_err) begin
            rdy_o  = err_second;
            resp_o = RSP_ERROR;
         end else begin
            rdy_o = wdone;
            if (!dp_write && wdone) rdata_o = mem_rd;
         end
      end
   end
endmodule

// File: rtl/memslv_ahb_chk.sv
module memslv_ahb_chk #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 32,
   parameter int DEPTH       = 64,
   parameter int WAIT_STATES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [1:0]        trans_i,
   input logic [2:0]        size_i,
   input logic              rdy_i,
   input logic              rdy_o,
   input logic [1:0]        resp_o
);
   localparam int OFS = $clog2(DATA_W / 8);
   localparam longint RANGE = longint'(DEPTH) * (DATA_W / 8);
   localparam bit ZW = (WAIT_STATES == 0);

   logic good_start;
   assign good_start = rdy_i && sel_i && trans_i[1] &&
                       (longint'(addr_i) < RANGE) && (size_i == 3'(OFS)) &&
                       (addr_i[OFS-1:0] == '0);

   // R8
   resp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_o[1] == 1'b0);

   // R7
   err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_o == 2'b01 && !rdy_o) |=> (resp_o == 2'b01 && rdy_o));

   // R7
   err_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_o == 2'b01 && rdy_o) |-> $past(resp_o == 2'b01 && !rdy_o));

   // R2
   idle_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_i && !(sel_i && trans_i[1])) |=> (rdy_o && resp_o == 2'b00));

   // R5
   wait_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      good_start |=> (rdy_o == ZW && resp_o == 2'b00));
endmodule

bind memslv_ahb memslv_ahb_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WAIT_STATES(WAIT_STATES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i), .trans_i(trans_i),
   .size_i(size_i), .rdy_i(rdy_i), .rdy_o(rdy_o), .resp_o(resp_o)
);

// File: tb/sim_memslv_ahb.sv
module sim_memslv_ahb;
   localparam int CLK_PERIOD = 10;
   localparam int WS = 1;

   typedef struct {
      logic [1:0]  resp;
      logic [1:0]  resp_low;
      int          waits;
      bit          chk_data;
      logic [31:0] data;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_i = 1'b0;
   logic [31:0] addr_i = '0;
   logic [1:0]  trans_i = 2'b00;
   logic        write_i = 1'b0;
   logic [2:0]  size_i = 3'd2;
   logic [2:0]  burst_i = 3'd0;
   logic        lock_i = 1'b0;
   logic [31:0] wdata_i = '0;
   logic        hold_low = 1'b0;
   logic        rdy_i, rdy_o;
   logic [1:0]  resp_o;
   logic [31:0] rdata_o;

   assign rdy_i = hold_low ? 1'b0 : rdy_o;

   memslv_ahb #(.DATA_W(32), .ADDR_W(32), .DEPTH(64), .WAIT_STATES(WS)) u0 (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i), .trans_i(trans_i),
      .write_i(write_i), .size_i(size_i), .burst_i(burst_i), .lock_i(lock_i),
      .wdata_i(wdata_i), .rdy_i(rdy_i), .rdy_o(rdy_o), .resp_o(resp_o),
      .rdata_o(rdata_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          n_chk = 0, n_bad = 0;
   bit          finished = 1'b0;
   item_t       sb[$];
   logic [31:0] model [64];
   logic [31:0] pend_wd = '0;

   task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic xfer(bit sel, logic [1:0] tr, bit wr, logic [31:0] a,
                       logic [2:0] sz, logic [2:0] bst, logic [31:0] wd, string tag);
      item_t it;
      bit    act, bad;
      @(negedge clk);
      sel_i = sel; trans_i = tr; write_i = wr; addr_i = a; size_i = sz;
      burst_i = bst; wdata_i = pend_wd;
      forever begin
         if (rdy_o) begin
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
      #1;
      act = sel && tr[1];
      bad = (a >= 32'd256) || (sz != 3'd2) || (a[1:0] != 2'b00);
      it.tag = tag; it.chk_data = 1'b0; it.data = '0;
      if (!act) begin
         it.resp = 2'b00; it.resp_low = 2'b00; it.waits = 0;
      end else if (bad) begin
         it.resp = 2'b01; it.resp_low = 2'b01; it.waits = 1;
      end else begin
         it.resp = 2'b00; it.resp_low = 2'b00; it.waits = WS;
         if (wr) model[a[7:2]] = wd;
         else begin
            it.chk_data = 1'b1;
            it.data = model[a[7:2]];
         end
      end
      sb.push_back(it);
      pend_wd = wd;
   endtask

   task automatic idle();
      xfer(1'b0, 2'b00, 1'b0, 32'h0, 3'd2, 3'd0, 32'h0, "R2 idle");
   endtask

   // monitor: compares the head of the scoreboard queue
   initial begin
      int waits = 0;
      forever begin
         @(negedge clk);
         if (rst_n && sb.size() > 0) begin
            if (!rdy_o) begin
               waits++;
               check(resp_o === sb[0].resp_low, {sb[0].tag, " R8 resp in wait"},
                     32'(resp_o), 32'(sb[0].resp_low));
            end else begin
               check(waits == sb[0].waits, {sb[0].tag, " R5 wait count"},
                     32'(waits), 32'(sb[0].waits));
               check(resp_o === sb[0].resp, {sb[0].tag, " R8 resp"},
                     32'(resp_o), 32'(sb[0].resp));
               if (sb[0].chk_data)
                  check(rdata_o === sb[0].data, {sb[0].tag, " rdata"},
                        rdata_o, sb[0].data);
               void'(sb.pop_front());
               waits = 0;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 reset state
      check(rdy_o === 1'b1, "R4 reset ready", 32'(rdy_o), 32'd1);
      check(resp_o === 2'b00, "R4 reset resp", 32'(resp_o), 32'd0);
      xfer(1'b1, 2'b10, 1'b0, 32'h10, 3'd2, 3'd0, 32'h0, "R4 unwritten read");
      // R3 single write then read
      xfer(1'b1, 2'b10, 1'b1, 32'h20, 3'd2, 3'd0, 32'hA5A5_1234, "R3 write");
      idle();
      xfer(1'b1, 2'b10, 1'b0, 32'h20, 3'd2, 3'd0, 32'h0, "R3 read");
      // R3 back-to-back
      xfer(1'b1, 2'b10, 1'b1, 32'h24, 3'd2, 3'd0, 32'h0BAD_F00D, "R3 b2b write");
      xfer(1'b1, 2'b10, 1'b0, 32'h24, 3'd2, 3'd0, 32'h0, "R3 b2b read");
      // R6 four-beat incrementing burst
      for (int b = 0; b < 4; b++)
         xfer(1'b1, (b == 0) ? 2'b10 : 2'b11, 1'b1, 32'h40 + 32'(4*b), 3'd2, 3'b011,
              32'h1000 + 32'(b), "R6 incr4 write");
      for (int b = 0; b < 4; b++)
         xfer(1'b1, (b == 0) ? 2'b10 : 2'b11, 1'b0, 32'h40 + 32'(4*b), 3'd2, 3'b011,
              32'h0, "R6 incr4 read");
      // R6 eight-beat burst with a BUSY beat
      for (int b = 0; b < 8; b++) begin
         xfer(1'b1, (b == 0) ? 2'b10 : 2'b11, 1'b1, 32'h80 + 32'(4*b), 3'd2, 3'b101,
              32'hC0DE_0000 + 32'(b*17), "R6 incr8 write");
         if (b == 3)
            xfer(1'b1, 2'b01, 1'b1, 32'h80 + 32'(4*b+4), 3'd2, 3'b101, 32'h0, "R2 busy");
      end
      for (int b = 0; b < 8; b++)
         xfer(1'b1, (b == 0) ? 2'b10 : 2'b11, 1'b0, 32'h80 + 32'(4*b), 3'd2, 3'b101,
              32'h0, "R6 incr8 read");
      // R1/R2 unselected and IDLE writes do nothing
      xfer(1'b0, 2'b10, 1'b1, 32'h30, 3'd2, 3'd0, 32'hFFFF_0001, "R1 unselected write");
      xfer(1'b1, 2'b00, 1'b1, 32'h34, 3'd2, 3'd0, 32'hFFFF_0002, "R2 idle write");
      xfer(1'b1, 2'b10, 1'b0, 32'h30, 3'd2, 3'd0, 32'h0, "R1 readback");
      xfer(1'b1, 2'b10, 1'b0, 32'h34, 3'd2, 3'd0, 32'h0, "R2 readback");
      // R7 errors
      xfer(1'b1, 2'b10, 1'b1, 32'h100, 3'd2, 3'd0, 32'hEEEE_0001, "R7 out of range");
      idle();
      xfer(1'b1, 2'b10, 1'b1, 32'h38, 3'd1, 3'd0, 32'hEEEE_0002, "R7 bad size");
      idle();
      xfer(1'b1, 2'b10, 1'b1, 32'h3A, 3'd2, 3'd0, 32'hEEEE_0003, "R7 misaligned");
      xfer(1'b1, 2'b10, 1'b0, 32'h38, 3'd2, 3'd0, 32'h0, "R7 no write");
      idle();
      while (sb.size() > 0) @(negedge clk);
      // R1 address phase ignored while bus ready is low
      sel_i = 1'b1; trans_i = 2'b10; write_i = 1'b1; addr_i = 32'h3C;
      size_i = 3'd2; wdata_i = 32'hDEAD_BEEF; hold_low = 1'b1;
      @(negedge clk);
      hold_low = 1'b0; sel_i = 1'b0; trans_i = 2'b00;
      check(rdy_o === 1'b1, "R1 ready-low ignored", 32'(rdy_o), 32'd1);
      @(negedge clk);
      check(resp_o === 2'b00, "R1 ready-low resp", 32'(resp_o), 32'd0);
      xfer(1'b1, 2'b10, 1'b0, 32'h3C, 3'd2, 3'd0, 32'h0, "R1 ready-low readback");
      idle();
      while (sb.size() > 0) @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule